// File: doc/BRIEF.md
# Converter Serial Readout Interface

This block is the digital side of a 16-bit sampling converter used as a three-wire slave, with no end-of-conversion flag. One input, the convert strobe, serves two roles. Its rising edge starts a conversion. While it is low, the serial output is enabled, acting as a chip select. The conversion lasts a fixed number of system clocks. When the conversion timer expires, the block takes the conversion word from a result stub over a valid/ready handshake. It then waits in an acquisition phase until the host reads the word.

The host reads by pulling the strobe low. The most significant bit appears on the serial output at once. Each later falling edge of the serial clock moves out the next bit. The output returns to high impedance after the last falling edge, or as soon as the strobe rises, whichever comes first.

The strobe and the serial clock are asynchronous to the system clock and pass through two-flop synchronizers. The serial clock must run at no more than a quarter of the system clock.

The result port follows valid/ready rules. `res_ready` is high only after the conversion timer has expired, and only until a word is taken. A word transfers on any cycle where both `res_valid` and `res_ready` are high. The stub may hold `res_valid` low for as long as it likes, and the block waits. While `res_ready` is low, `res_valid` is ignored.

Top module: `cnv_readout`

## Requirements
- R1: After reset, `sdo_en` and `res_ready` are 0.
- R2: A rising edge of `cnv` outside a conversion starts a conversion of `CONV_CYCLES` system clocks. During the conversion `sdo_en` is 0 and `res_ready` is 0. `res_ready` rises when the conversion ends.
- R3: A conversion runs to completion whatever `cnv` does. A fall and a new rise of `cnv` during the conversion neither restart it nor delay `res_ready`.
- R4: The result word is taken only when `res_valid` and `res_ready` are both high. Until it is taken, `sdo_en` stays 0 even with `cnv` low.
- R5: Once the word has been taken, `cnv` low drives `sdo_en` to 1, and `sdo_d` carries bit 15 of the word.
- R6: If `cnv` falls before the conversion ends, `sdo_en` stays 0 until the word is taken. If `cnv` is still low at that point, bit 15 is then driven.
- R7: Each falling edge of `sck` during readout presents the next lower bit, bits 14 down to 0 in turn. `sdo_d` does not change on a rising edge of `sck`.
- R8: The 16th falling edge of `sck` sets `sdo_en` to 0. Further `sck` edges leave it at 0 until the next conversion.
- R9: A rising edge of `cnv` during readout sets `sdo_en` to 0 and starts a new conversion. This also holds when the rise lands in the same system cycle as the 16th falling edge of `sck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv | input | 1 | Convert strobe and active-low select, asynchronous |
| sck | input | 1 | Serial clock from host, asynchronous |
| res_valid | input | 1 | Result stub offers a word |
| res_ready | output | 1 | Block is ready to take the result word |
| res_data | input | 16 | Conversion result word |
| sdo_d | output | 1 | Serial data value |
| sdo_en | output | 1 | Output enable for the serial data pad |

## Verification
Two functions can fall in the same system cycle. One is the stop after the 16th falling edge of `sck`. The other is the abort and restart caused by a `cnv` rise. The bench provokes this by driving the final `sck` fall and the `cnv` rise on the same clock edge, so both synchronized edges arrive together. It judges the outcome by two results. `sdo_en` must go to 0. `res_ready` must rise one conversion time later, which shows the restart won and was not dropped by the stop path.

// File: rtl/cnv_readout_pkg.sv
package cnv_readout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_ACQ,
    ST_READ,
    ST_DONE
  } rd_state_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CONV_CYCLES = 40,
  localparam int CNT_W = $clog2(CONV_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start) begin
      cnt_q  <= CNT_W'(CONV_CYCLES - 1);
      busy_q <= 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  // R3: once running, the timer keeps going until its count runs out
  assert_runs_to_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cnt_q != '0 |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int DATA_W = 16,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              msb,
  output logic              last
);
  logic [DATA_W-1:0] sh_q;
  logic [BIT_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_data;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign msb  = sh_q[DATA_W-1];
  assign last = (idx_q == BIT_W'(DATA_W - 1));
endmodule

// File: rtl/cnv_readout.sv
module cnv_readout
  import cnv_readout_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              sdo_d,
  output logic              sdo_en
);
  rd_state_t state_q, state_d;
  logic cnv_lvl, cnv_rise, cnv_fall;
  logic sck_lvl, sck_rise, sck_fall;
  logic tmr_start, tmr_busy, tmr_done;
  logic sh_load, sh_shift, sh_msb, sh_last;
  logic take;

  edge_sync u_cnv_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cnv),
    .level(cnv_lvl), .rise(cnv_rise), .fall(cnv_fall)
  );

  edge_sync u_sck_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sck),
    .level(sck_lvl), .rise(sck_rise), .fall(sck_fall)
  );

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start),
    .busy(tmr_busy), .done(tmr_done)
  );

  word_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_data(res_data),
    .shift(sh_shift), .msb(sh_msb), .last(sh_last)
  );

  assign take      = (state_q == ST_WAIT) && res_valid;
  assign sh_load   = take;
  assign res_ready = (state_q == ST_WAIT);
  assign sdo_en    = (state_q == ST_READ);
  assign sdo_d     = sh_msb;

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    sh_shift  = 1'b0;
    unique case (state_q)
      ST_CONV: if (tmr_done) state_d = ST_WAIT;
      ST_WAIT: if (res_valid) state_d = ST_ACQ;
      ST_ACQ:  if (!cnv_lvl) state_d = ST_READ;
      ST_READ: begin
        if (cnv_rise) begin
          state_d   = ST_CONV;
          tmr_start = 1'b1;
        end else if (sck_fall) begin
          if (sh_last) state_d = ST_DONE;
          else         sh_shift = 1'b1;
        end
      end
      default: begin
        if (cnv_rise) begin
          state_d   = ST_CONV;
          tmr_start = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R9: a select rise during readout releases the output next cycle
  assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en && cnv_rise |=> !sdo_en && tmr_busy);

  // R7: data only moves after a synchronized falling clock edge
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en && $past(sdo_en) && !$past(sck_fall) |-> sdo_d == $past(sdo_d));

  // R2: the handshake and the output never overlap a running conversion
  assert_quiet_in_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> !sdo_en && !res_ready);

  // R5: the output only turns on while the select is low
  assert_enable_when_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> !$past(cnv_lvl));

  // R4: waiting for a word keeps the pad released
  assert_wait_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready && !res_valid |=> !sdo_en);
endmodule

// File: tb/cnv_readout_tb.sv
module cnv_readout_tb;
  localparam int DW = 16;
  localparam int TC = 40;
  localparam int S  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, sck = 1'b0, res_valid = 1'b1;
  logic [DW-1:0] res_data = '0;
  logic res_ready, sdo_d, sdo_en;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    logic en;
    logic d;
    logic chk_d;
    logic rdy;
    logic chk_rdy;
    string req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  cnv_readout #(.DATA_W(DW), .CONV_CYCLES(TC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .sdo_d(sdo_d), .sdo_en(sdo_en)
  );

  // monitor: compares queued expectations after outputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (sdo_en !== e.en ||
            (e.chk_d && sdo_d !== e.d) ||
            (e.chk_rdy && res_ready !== e.rdy)) begin
          errors++;
          $display("FAIL %s: en=%b d=%b rdy=%b expected en=%b d=%b rdy=%b",
                   e.req, sdo_en, sdo_d, res_ready, e.en, e.d, e.rdy);
        end
      end
    end
  end

  task automatic expect_out(input logic en, input logic chk_d, input logic d,
                            input logic chk_rdy, input logic rdy, input string req);
    exp_t e;
    e.en = en; e.d = d; e.chk_d = chk_d; e.rdy = rdy; e.chk_rdy = chk_rdy; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n serial bits after bit 15 has been checked; last fall expected to release
  task automatic read_bits(input logic [DW-1:0] w, input int n, input bit full);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1;
      wait_clk(S);
      expect_out(1'b1, 1'b1, w[DW-1-i], 1'b0, 1'b0, "R7 hold on rise");
      sck = 1'b0;
      wait_clk(S);
      if (full && i == DW-1) expect_out(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 release after 16th fall");
      else expect_out(1'b1, 1'b1, w[DW-2-i], 1'b0, 1'b0, "R7 next bit");
    end
  endtask

  initial begin
    wait_clk(3);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 reset");
    rst_n = 1'b1;
    wait_clk(2);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 after reset");

    // normal conversion and full read
    res_data = 16'hB2E7;
    cnv = 1'b1;
    wait_clk(20);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 during conversion");
    wait_clk(30);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 acquisition with cnv high");
    cnv = 1'b0;
    wait_clk(S);
    expect_out(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 msb on select");
    read_bits(16'hB2E7, DW, 1'b1);
    sck = 1'b1; wait_clk(S); sck = 1'b0; wait_clk(S);
    expect_out(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 extra sck ignored");
    cnv = 1'b1;
    wait_clk(S);

    // select falls early during conversion
    res_data = 16'h4D19;
    cnv = 1'b0; wait_clk(S);
    cnv = 1'b1; wait_clk(4);
    cnv = 1'b0;
    wait_clk(10);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 no output before end");
    wait_clk(36);
    expect_out(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R6 msb after end");
    read_bits(16'h4D19, DW, 1'b1);

    // no restart during conversion, and back-pressure on the result
    res_valid = 1'b0;
    res_data  = 16'h8001;
    cnv = 1'b1;
    wait_clk(20);
    cnv = 1'b0; wait_clk(4);
    cnv = 1'b1;
    wait_clk(26);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 ready on original schedule");
    cnv = 1'b0;
    wait_clk(S);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 no output without word");
    res_valid = 1'b1;
    wait_clk(S);
    expect_out(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R4 word taken msb out");
    read_bits(16'h8001, 5, 1'b0);

    // abort mid-readout
    res_data = 16'h7F02;
    cnv = 1'b1;
    wait_clk(S);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 abort releases output");
    wait_clk(50);
    cnv = 1'b0;
    wait_clk(S);
    expect_out(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 new word after abort");
    read_bits(16'h7F02, DW-1, 1'b0);

    // 16th fall and select rise in the same cycle
    res_valid = 1'b0;
    sck = 1'b1;
    wait_clk(S);
    sck = 1'b0;
    cnv = 1'b1;
    wait_clk(S);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 coincident release");
    wait_clk(44);
    expect_out(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 coincident restart ready");
    res_data = 16'hC3A5;
    res_valid = 1'b1;
    cnv = 1'b0;
    wait_clk(S);
    expect_out(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 msb after coincident restart");
    read_bits(16'hC3A5, DW, 1'b1);

    wait_clk(3);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule